// File: doc/BRIEF.md
# Counter-Aware Bit-Modifying Test Pattern Generator

This block is a built-in self-test source for a scan chain. A very short LFSR feeds a serial stream toward a scan register. A combinational flip function sits between them. The flip function does not look only at the LFSR state. It also sees the position of the current bit inside the pattern and the index of the current pattern. This means a generator whose raw sequence repeats every few bits can still place chosen deterministic values at chosen positions in chosen patterns. Each serial bit is the LFSR output bit XORed with the flip function, and that bit is shifted into the scan register.

The flip function is a sum of cubes. Each cube is a value/mask pair that is compared against the vector `{pattern counter, bit counter, LFSR state}`. Masked-off bits are don't-cares. The output bit is inverted when at least one cube matches. The cubes, the cube count, the LFSR seed and taps, the pattern length and the number of patterns are all parameters. The LFSR runs through the whole test without reseeding. When the last pattern has been shifted in, the block raises a sticky completion flag and freezes.

The default configuration is the smallest useful one: a 2-bit LFSR, 5-bit patterns, a test length of six patterns and two cubes. With these defaults the unmodified stream would repeat every three bits. The two cubes turn it into six distinct target patterns.

Top module: `cube_flip_tpg`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to its initial state. After that edge `scan_vec` is all zeros, `scan_bit`, `pat_valid` and `done` are low, and `pat_idx` is 0.
- R2: The LFSR has width `LFSR_W`, starts at `SEED`, and emits its most significant bit. Each advance computes next = {state[W-2:0], XOR of (state AND TAPS)}. With the defaults (seed 2'b10, taps 2'b11) the raw serial stream is 1,0,1 repeating, so the unflipped patterns are 10110, 11011, 01101, 10110, 11011, 01101.
- R3: Each shifted bit equals the LFSR output bit XOR (OR over all cubes of ((V ^ value) & mask) == 0). Here V = {pattern counter, bit counter, LFSR state}, with the pattern counter in the most significant field and the LFSR state in the least significant field. Cube k occupies bits [k*VEC_W +: VEC_W] of `CUBE_VAL` and `CUBE_MASK`.
- R4: A shift moves `scan_vec` left and inserts the new bit at bit 0, which is also `scan_bit`. The first bit of a pattern therefore ends at `scan_vec[SCAN_LEN-1]`, and a pattern written left to right reads in shift order.
- R5: The bit counter counts 0..SCAN_LEN-1 over the advancing cycles. In the cycle after the edge that shifts in the last bit of a pattern, `pat_valid` is high for exactly one cycle, `scan_vec` holds the whole pattern, and `pat_idx` holds its index (0-based).
- R6: The LFSR is never reloaded between patterns. Pattern n+1 continues the state sequence where pattern n stopped.
- R7: `done` rises together with the `pat_valid` of pattern NUM_PAT-1 and stays high until reset. While `done` is high, `scan_vec`, `scan_bit` and `pat_idx` do not change and `pat_valid` stays low.
- R8: An edge with `en` low changes no state: the outputs keep their values and the sequence resumes unchanged when `en` returns high.
- R9: With the default cubes (value 8'b0000_0010 / mask 8'b0000_0110 and value 8'b0010_0001 / mask 8'b0010_0111), the six delivered patterns are 00010, 01110, 01000, 00011, 01010, 11000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Advance one bit this cycle when high |
| scan_bit | output | 1 | Most recent bit shifted into the scan register |
| scan_vec | output | SCAN_LEN | Scan register contents, first bit of a pattern at the MSB |
| pat_valid | output | 1 | One-cycle pulse: a full pattern is in `scan_vec` |
| pat_idx | output | clog2(NUM_PAT) | Index of the pattern flagged by `pat_valid` |
| done | output | 1 | Sticky end-of-test flag |

## Verification
The embedded assertions check the invariants that hold on every cycle:
- the LFSR never reaches the all-zero lock-up state and does not move on an idle edge;
- the bit counter stays within the pattern length;
- the completion pulse is never longer than one cycle;
- the final pulse coincides with `done`;
- `done` is sticky and freezes the scan register.

Other behaviour can only be shown by the bench's scenarios:
- the exact serial values, including the cube matching over the three counter fields and the XOR with the LFSR bit;
- the shift order;
- the continuity of the LFSR across pattern boundaries;
- the six reference patterns.

The bench drives two instances under randomly gated enables: one with the default cubes and one whose cubes can never match. It compares every cycle against a model built from the requirements.

// File: rtl/cube_flip_tpg_pkg.sv
package cube_flip_tpg_pkg;

    // widest cube vector the matching helper accepts
    localparam int CUBE_MAX_W = 32;

    typedef enum logic {
        PH_RUN  = 1'b0,
        PH_DONE = 1'b1
    } phase_e;

    // result of one generator step as seen by the scan register
    typedef struct packed {
        logic shift;    // a bit is produced this cycle
        logic bit_val;  // the produced bit
        logic closes;   // the bit completes a pattern
    } step_t;

    // a cube matches when every cared-for bit equals its value
    function automatic logic cube_hit(input logic [CUBE_MAX_W-1:0] vec,
                                      input logic [CUBE_MAX_W-1:0] val,
                                      input logic [CUBE_MAX_W-1:0] msk);
        return ((vec ^ val) & msk) == '0;
    endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr #(
    parameter int              W    = 2,
    parameter logic [W-1:0]    SEED = 2'b10,
    parameter logic [W-1:0]    TAPS = 2'b11
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] state,
    output logic         out_bit
);

    logic fb;
    assign fb      = ^(state & TAPS);
    assign out_bit = state[W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else if (adv) begin
            state <= {state[W-2:0], fb};
        end
    end

    // R2
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        state != '0);

    // R8
    lfsr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

endmodule

// File: rtl/tpg_position.sv
module tpg_position
    import cube_flip_tpg_pkg::*;
#(
    parameter int SCAN_LEN = 5,
    parameter int NUM_PAT  = 6,
    localparam int BIT_CW  = $clog2(SCAN_LEN),
    localparam int PAT_CW  = $clog2(NUM_PAT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    output logic [BIT_CW-1:0] bit_cnt,
    output logic [PAT_CW-1:0] pat_cnt,
    output logic              last_bit,
    output logic              done
);

    localparam logic [BIT_CW-1:0] BIT_LAST = BIT_CW'(SCAN_LEN - 1);
    localparam logic [PAT_CW-1:0] PAT_LAST = PAT_CW'(NUM_PAT - 1);

    phase_e phase;

    assign last_bit = (bit_cnt == BIT_LAST);
    assign done     = (phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            bit_cnt <= '0;
            pat_cnt <= '0;
            phase   <= PH_RUN;
        end else if (adv) begin
            if (last_bit) begin
                bit_cnt <= '0;
                if (pat_cnt == PAT_LAST) begin
                    phase <= PH_DONE;
                end else begin
                    pat_cnt <= pat_cnt + 1'b1;
                end
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // R5
    bit_range_chk: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= BIT_LAST);

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

endmodule

// File: rtl/tpg_flip.sv
module tpg_flip
    import cube_flip_tpg_pkg::*;
#(
    parameter int                         VEC_W     = 8,
    parameter int                         NUM_CUBES = 2,
    parameter logic [NUM_CUBES*VEC_W-1:0] CUBE_VAL  = '0,
    parameter logic [NUM_CUBES*VEC_W-1:0] CUBE_MASK = '0
) (
    input  logic [VEC_W-1:0] vec,
    output logic             flip
);

    logic [NUM_CUBES-1:0] hits;

    for (genvar k = 0; k < NUM_CUBES; k++) begin : g_cube
        localparam logic [VEC_W-1:0] VAL = CUBE_VAL[k*VEC_W +: VEC_W];
        localparam logic [VEC_W-1:0] MSK = CUBE_MASK[k*VEC_W +: VEC_W];
        assign hits[k] = cube_hit(CUBE_MAX_W'(vec), CUBE_MAX_W'(VAL),
                                  CUBE_MAX_W'(MSK));
    end

    assign flip = |hits;

    initial begin
        // R3
        vec_width_chk: assert (VEC_W <= CUBE_MAX_W);
    end

endmodule

// File: rtl/cube_flip_tpg.sv
module cube_flip_tpg
    import cube_flip_tpg_pkg::*;
#(
    parameter int               LFSR_W    = 2,
    parameter logic [LFSR_W-1:0] SEED     = 2'b10,
    parameter logic [LFSR_W-1:0] TAPS     = 2'b11,
    parameter int               SCAN_LEN  = 5,
    parameter int               NUM_PAT   = 6,
    parameter int               NUM_CUBES = 2,
    parameter logic [NUM_CUBES*($clog2(NUM_PAT)+$clog2(SCAN_LEN)+LFSR_W)-1:0]
                                CUBE_VAL  = {8'b0010_0001, 8'b0000_0010},
    parameter logic [NUM_CUBES*($clog2(NUM_PAT)+$clog2(SCAN_LEN)+LFSR_W)-1:0]
                                CUBE_MASK = {8'b0010_0111, 8'b0000_0110}
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    output logic                        scan_bit,
    output logic [SCAN_LEN-1:0]         scan_vec,
    output logic                        pat_valid,
    output logic [$clog2(NUM_PAT)-1:0]  pat_idx,
    output logic                        done
);

    localparam int BIT_CW = $clog2(SCAN_LEN);
    localparam int PAT_CW = $clog2(NUM_PAT);
    localparam int VEC_W  = PAT_CW + BIT_CW + LFSR_W;

    logic              adv;
    logic [LFSR_W-1:0] lfsr_state;
    logic              lfsr_bit;
    logic [BIT_CW-1:0] bit_cnt;
    logic [PAT_CW-1:0] pat_cnt;
    logic              last_bit;
    logic              flip;
    step_t             step;

    assign adv = en && !done;

    tpg_lfsr #(.W(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .state   (lfsr_state),
        .out_bit (lfsr_bit)
    );

    tpg_position #(.SCAN_LEN(SCAN_LEN), .NUM_PAT(NUM_PAT)) u_pos (
        .clk      (clk),
        .rst      (rst),
        .adv      (adv),
        .bit_cnt  (bit_cnt),
        .pat_cnt  (pat_cnt),
        .last_bit (last_bit),
        .done     (done)
    );

    tpg_flip #(
        .VEC_W     (VEC_W),
        .NUM_CUBES (NUM_CUBES),
        .CUBE_VAL  (CUBE_VAL),
        .CUBE_MASK (CUBE_MASK)
    ) u_flip (
        .vec  ({pat_cnt, bit_cnt, lfsr_state}),
        .flip (flip)
    );

    always_comb begin
        step.shift   = adv;
        step.bit_val = lfsr_bit ^ flip;
        step.closes  = adv && last_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_vec  <= '0;
            pat_valid <= 1'b0;
            pat_idx   <= '0;
        end else begin
            pat_valid <= step.closes;
            if (step.shift) begin
                scan_vec <= {scan_vec[SCAN_LEN-2:0], step.bit_val};
            end
            if (step.closes) begin
                pat_idx <= pat_cnt;
            end
        end
    end

    assign scan_bit = scan_vec[0];

    // R5
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        pat_valid |=> !pat_valid);

    // R7
    final_done_chk: assert property (@(posedge clk) disable iff (rst)
        (pat_valid && pat_idx == PAT_CW'(NUM_PAT - 1)) |-> done);

    // R7
    frozen_scan_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(scan_vec));

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !pat_valid) |=> ($stable(scan_vec) && !pat_valid));

endmodule

// File: tb/cube_flip_tpg_test.sv
module cube_flip_tpg_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    always #2 clk = ~clk;

    logic       sb [2];
    logic [4:0] sv [2];
    logic       pv [2];
    logic [2:0] pi [2];
    logic       dn [2];

    // default cubes
    cube_flip_tpg uut (
        .clk(clk), .rst(rst), .en(en),
        .scan_bit(sb[0]), .scan_vec(sv[0]), .pat_valid(pv[0]),
        .pat_idx(pi[0]), .done(dn[0])
    );

    // cubes that demand bit counter 7: never reached, so no flips
    cube_flip_tpg #(
        .CUBE_VAL ({8'b0001_1100, 8'b0001_1100}),
        .CUBE_MASK({8'b0001_1100, 8'b0001_1100})
    ) raw (
        .clk(clk), .rst(rst), .en(en),
        .scan_bit(sb[1]), .scan_vec(sv[1]), .pat_valid(pv[1]),
        .pat_idx(pi[1]), .done(dn[1])
    );

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    logic [1:0] m_lfsr [2];
    logic [2:0] m_bit  [2];
    logic [2:0] m_pat  [2];
    logic [4:0] m_scan [2];
    logic       m_val  [2];
    logic [2:0] m_idx  [2];
    logic       m_done [2];

    function automatic logic [4:0] ref_pattern(input int k, input int i);
        logic [4:0] tgt [6];
        logic [4:0] unf [3];
        tgt[0] = 5'b00010; tgt[1] = 5'b01110; tgt[2] = 5'b01000;
        tgt[3] = 5'b00011; tgt[4] = 5'b01010; tgt[5] = 5'b11000;
        unf[0] = 5'b10110; unf[1] = 5'b11011; unf[2] = 5'b01101;
        return (k == 0) ? tgt[i] : unf[i % 3];
    endfunction

    // R3: flip from the default cube list, decoded field by field
    function automatic logic flip_of(input int k, input logic [2:0] p,
                                     input logic [2:0] b, input logic [1:0] s);
        if (k != 0) return 1'b0;
        return (!b[0] && s[1]) || (p[0] && !b[0] && s == 2'b01);
    endfunction

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input logic r, input logic e);
        for (int k = 0; k < 2; k++) begin
            if (r) begin
                m_lfsr[k] = 2'b10; m_bit[k] = '0; m_pat[k] = '0;
                m_scan[k] = '0; m_val[k] = 1'b0; m_idx[k] = '0; m_done[k] = 1'b0;
            end else begin
                m_val[k] = 1'b0;
                if (e && !m_done[k]) begin
                    logic nb;
                    nb = m_lfsr[k][1] ^ flip_of(k, m_pat[k], m_bit[k], m_lfsr[k]);
                    m_scan[k] = {m_scan[k][3:0], nb};
                    m_lfsr[k] = {m_lfsr[k][0], m_lfsr[k][1] ^ m_lfsr[k][0]};
                    if (m_bit[k] == 3'd4) begin
                        m_bit[k] = '0;
                        m_val[k] = 1'b1;
                        m_idx[k] = m_pat[k];
                        if (m_pat[k] == 3'd5) m_done[k] = 1'b1;
                        else m_pat[k] = m_pat[k] + 1'b1;
                    end else begin
                        m_bit[k] = m_bit[k] + 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic compare_all(input string req);
        for (int k = 0; k < 2; k++) begin
            check(req, "scan_vec", int'(sv[k]), int'(m_scan[k]));
            check(req, "scan_bit", int'(sb[k]), int'(m_scan[k][0]));
            check(req, "pat_valid", int'(pv[k]), int'(m_val[k]));
            check("R7", "done", int'(dn[k]), int'(m_done[k]));
            if (m_val[k]) begin
                check("R5", "pat_idx", int'(pi[k]), int'(m_idx[k]));
                check(k == 0 ? "R9" : "R2", "pattern", int'(sv[k]),
                      int'(ref_pattern(k, int'(m_idx[k]))));
            end
        end
    endtask

    task automatic tick(input logic r, input logic e, input string req);
        rst = r;
        en  = e;
        model_step(r, e);
        @(negedge clk);
        cyc++;
        compare_all(req);
    endtask

    initial begin
        process::self().srandom(32'd7031);
        void'($urandom(32'd7031));

        // R1: reset state
        tick(1'b1, 1'b0, "R1");
        tick(1'b1, 1'b1, "R1");
        for (int k = 0; k < 2; k++) begin
            check("R1", "scan_vec reset", int'(sv[k]), 0);
            check("R1", "pat_idx reset", int'(pi[k]), 0);
        end

        // R8: idle cycles right after reset change nothing
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, "R8");

        // R3 R4 R6: randomly gated run to the end
        for (int i = 0; i < 80; i++) tick(1'b0, ($urandom % 4) != 0, "R3");

        // R7: frozen after completion
        for (int i = 0; i < 12; i++) tick(1'b0, 1'b1, "R7");

        // R6: reset mid-test, partial run, long pause, resume
        tick(1'b1, 1'b0, "R1");
        for (int i = 0; i < 7; i++) tick(1'b0, 1'b1, "R6");
        for (int i = 0; i < 9; i++) tick(1'b0, 1'b0, "R8");
        for (int i = 0; i < 40; i++) tick(1'b0, 1'b1, "R4");

        // R9: back-to-back run with enable always high
        tick(1'b1, 1'b0, "R1");
        for (int i = 0; i < 35; i++) tick(1'b0, 1'b1, "R9");
        check("R9", "final pattern", int'(sv[0]), int'(5'b11000));
        check("R2", "raw final pattern", int'(sv[1]), int'(5'b01101));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected<%0d", cyc, 5000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule